// File: doc/BRIEF.md
# Masked Bus Match Comparator

This block watches one CPU bus access per clock cycle and compares it against a set of stored settings that a register file supplies. It compares the full address, and optionally the access direction. Depending on how it is built, it also compares either the data, bit by bit under a mask and optionally inverted, or the access size. A hit produces a registered one-cycle match flag. Later logic can route that flag to a break or trace trigger.

The build-time parameter `KIND` selects one of two variants. The data-capable variant compares data and ignores the size settings. The size-capable variant compares the access size and ignores the data, mask and inversion settings. A tag-mode setting bypasses both the data compare and the size compare, so that only the address and direction checks stay in force.

A small state machine carries the result. State ST_OFF is held while the comparator is disabled. State ST_WATCH means enabled with no hit on the last access. State ST_HIT means the last access matched. The transitions are:

- ANY->ST_OFF when the enable is low.
- ANY->ST_HIT when the enable is high and a valid access matches.
- ANY->ST_WATCH when the enable is high and there is no valid matching access.

The match flag is high exactly in ST_HIT.

Top module: `bus_match_cmp`

## Requirements
- R1: `match_o` is a registered flag. It is high in the cycle after an access that has `bus_valid` high and that passes every enabled compare. It is low after any cycle with `bus_valid` low, and it is low while reset is active.
- R2: An access can match only if all ADDR_W bits of `bus_addr` equal `cfg_addr`.
- R3: When `cfg_rwe` is 1, an access matches only if `bus_rd` equals `cfg_rd` (1 = read). When `cfg_rwe` is 0, the direction has no effect.
- R4: In the data variant (KIND_DATA) with `cfg_invert`=0, the data compare passes when every bit with `cfg_mask` bit = 1 has the same value in `bus_data` and `cfg_data`. Bits whose mask bit is 0 are excluded.
- R5: In the data variant with `cfg_invert`=1, the data compare passes when at least one unmasked bit differs. If the whole mask is 0, the compare never passes.
- R6: When `cfg_tag` is 1, the data compare and the size compare are treated as passed, whatever the values of `cfg_invert` and `cfg_size_en`.
- R7: In the size variant (KIND_SIZE) with `cfg_size_en`=1, an access matches only if `bus_word` (1 = word, 0 = byte) equals `cfg_size_word`. With `cfg_size_en`=0, the size has no effect.
- R8: The data variant is unaffected by the size settings and by `bus_word`. The size variant is unaffected by `bus_data`, `cfg_data`, `cfg_mask` and `cfg_invert`.
- R9: While `cfg_en` is 0, `match_o` stays 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus data |
| bus_rd | input | 1 | Direction, 1 = read |
| bus_word | input | 1 | Size, 1 = word, 0 = byte |
| cfg_en | input | 1 | Comparator enable |
| cfg_tag | input | 1 | Tag mode, bypasses the data and size compares |
| cfg_rwe | input | 1 | Direction compare enable |
| cfg_rd | input | 1 | Required direction |
| cfg_invert | input | 1 | Match on data inequality (data variant) |
| cfg_size_en | input | 1 | Size compare enable (size variant) |
| cfg_size_word | input | 1 | Required size (size variant) |
| cfg_addr | input | ADDR_W | Stored address |
| cfg_data | input | DATA_W | Stored data |
| cfg_mask | input | DATA_W | Per-bit data mask, 1 = compared |
| match_o | output | 1 | Registered match pulse |

## Verification
Every result of this block arrives exactly one clock edge after the access that causes it, because the only register in the path is the state register. The bench drives each access on a falling edge. It then samples `match_o` at the next falling edge, half a period after the state register has updated. No sample is taken before that edge or two edges later. The bench drives the same stimulus into both variants and computes the expected flag for each one arithmetically from the stimulus. The disable case and the missing-strobe case are checked at the same one-cycle offset.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_SIZE = 1'b1
    } cmp_kind_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_HIT   = 2'd2
    } cmp_state_e;
endpackage

// File: rtl/bmc_attr_cmp.sv
module bmc_attr_cmp #(
    parameter int ADDR_W = 23
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic              bus_rd,
    input  logic              ref_rd,
    input  logic              dir_en,
    output logic              ok
);
    logic addr_same;
    logic dir_ok;

    always_comb begin
        addr_same = (bus_addr == ref_addr);
        dir_ok    = !dir_en || (bus_rd == ref_rd);
        ok        = addr_same && dir_ok;
    end
endmodule

// File: rtl/bmc_data_cmp.sv
module bmc_data_cmp #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] bus_data,
    input  logic [DATA_W-1:0] ref_data,
    input  logic [DATA_W-1:0] mask,
    input  logic              invert,
    input  logic              bypass,
    output logic              ok
);
    logic [DATA_W-1:0] diff_bits;
    logic              any_diff;

    always_comb begin
        diff_bits = (bus_data ^ ref_data) & mask;
        any_diff  = |diff_bits;
        if (bypass) ok = 1'b1;
        else if (invert) ok = any_diff;
        else ok = !any_diff;
    end
endmodule

// File: rtl/bmc_size_cmp.sv
module bmc_size_cmp (
    input  logic bus_word,
    input  logic want_word,
    input  logic size_en,
    input  logic bypass,
    output logic ok
);
    always_comb begin
        ok = bypass || !size_en || (bus_word == want_word);
    end
endmodule

// File: rtl/bus_match_cmp.sv
module bus_match_cmp
    import bmc_pkg::*;
#(
    parameter int        ADDR_W = 23,
    parameter int        DATA_W = 16,
    parameter cmp_kind_e KIND   = KIND_DATA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rd,
    input  logic              bus_word,
    input  logic              cfg_en,
    input  logic              cfg_tag,
    input  logic              cfg_rwe,
    input  logic              cfg_rd,
    input  logic              cfg_invert,
    input  logic              cfg_size_en,
    input  logic              cfg_size_word,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [DATA_W-1:0] cfg_mask,
    output logic              match_o
);
    cmp_state_e state_q, state_d;
    logic attr_ok;
    logic kind_ok;
    logic hit;

    bmc_attr_cmp #(.ADDR_W(ADDR_W)) u_attr (
        .bus_addr (bus_addr),
        .ref_addr (cfg_addr),
        .bus_rd   (bus_rd),
        .ref_rd   (cfg_rd),
        .dir_en   (cfg_rwe),
        .ok       (attr_ok)
    );

    generate
        if (KIND == KIND_DATA) begin : g_data
            bmc_data_cmp #(.DATA_W(DATA_W)) u_data (
                .bus_data (bus_data),
                .ref_data (cfg_data),
                .mask     (cfg_mask),
                .invert   (cfg_invert),
                .bypass   (cfg_tag),
                .ok       (kind_ok)
            );

            assert_masked_inequality_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_invert && !cfg_tag && (cfg_mask == '0)) |=> !match_o);
        end else begin : g_size
            bmc_size_cmp u_size (
                .bus_word  (bus_word),
                .want_word (cfg_size_word),
                .size_en   (cfg_size_en),
                .bypass    (cfg_tag),
                .ok        (kind_ok)
            );

            assert_size_required_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_size_en && !cfg_tag && (bus_word != cfg_size_word)) |=> !match_o);
        end
    endgenerate

    assign hit = bus_valid && attr_ok && kind_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_WATCH, ST_HIT: begin
                if (!cfg_en) state_d = ST_OFF;
                else if (hit) state_d = ST_HIT;
                else state_d = ST_WATCH;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else state_q <= state_d;
    end

    always_comb begin
        match_o = (state_q == ST_HIT);
    end

    assert_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !match_o);
    assert_addr_required_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != cfg_addr) |=> !match_o);
    assert_dir_required_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rwe && (bus_rd != cfg_rd)) |=> !match_o);
    assert_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !match_o);
    assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3);
endmodule

// File: tb/test_bus_match_cmp.sv
`timescale 1ns/1ps
module test_bus_match_cmp;
    import bmc_pkg::*;
    localparam int AW = 23;
    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid, bus_rd, bus_word;
    logic [AW-1:0] bus_addr, cfg_addr;
    logic [DW-1:0] bus_data, cfg_data, cfg_mask;
    logic cfg_en, cfg_tag, cfg_rwe, cfg_rd, cfg_invert, cfg_size_en, cfg_size_word;
    logic match_a, match_b;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_match_cmp #(.ADDR_W(AW), .DATA_W(DW), .KIND(KIND_DATA)) i_bus_match_cmp (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_rd(bus_rd), .bus_word(bus_word), .cfg_en(cfg_en),
        .cfg_tag(cfg_tag), .cfg_rwe(cfg_rwe), .cfg_rd(cfg_rd), .cfg_invert(cfg_invert),
        .cfg_size_en(cfg_size_en), .cfg_size_word(cfg_size_word), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_mask(cfg_mask), .match_o(match_a));

    bus_match_cmp #(.ADDR_W(AW), .DATA_W(DW), .KIND(KIND_SIZE)) i_bus_match_cmp_sz (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_rd(bus_rd), .bus_word(bus_word), .cfg_en(cfg_en),
        .cfg_tag(cfg_tag), .cfg_rwe(cfg_rwe), .cfg_rd(cfg_rd), .cfg_invert(cfg_invert),
        .cfg_size_en(cfg_size_en), .cfg_size_word(cfg_size_word), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_mask(cfg_mask), .match_o(match_b));

    function automatic logic common_ok();
        return cfg_en && bus_valid && (bus_addr == cfg_addr) && (!cfg_rwe || bus_rd == cfg_rd);
    endfunction

    function automatic logic exp_a();
        logic [DW-1:0] d;
        logic dok;
        d = (bus_data ^ cfg_data) & cfg_mask;
        dok = cfg_tag ? 1'b1 : (cfg_invert ? (d != 0) : (d == 0));
        return common_ok() && dok;
    endfunction

    function automatic logic exp_b();
        logic sok;
        sok = cfg_tag || !cfg_size_en || (bus_word == cfg_size_word);
        return common_ok() && sok;
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: match actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge (one register).
    task automatic step(input string ra, input string rb);
        logic ea, eb;
        ea = exp_a();
        eb = exp_b();
        @(negedge clk);
        check(match_a, ea, ra);
        check(match_b, eb, rb);
    endtask

    initial begin
        bus_valid = 0; bus_rd = 0; bus_word = 0; bus_addr = '0; bus_data = '0;
        cfg_en = 0; cfg_tag = 0; cfg_rwe = 0; cfg_rd = 0; cfg_invert = 0;
        cfg_size_en = 0; cfg_size_word = 0; cfg_addr = 23'h5A_3C71;
        cfg_data = 4'hA; cfg_mask = 4'hF;
        repeat (3) @(negedge clk);
        check(match_a, 1'b0, "R1 reset");
        check(match_b, 1'b0, "R1 reset");
        rst_n = 1;
        @(negedge clk);

        // R9: disabled comparator never matches even with a perfect access
        cfg_en = 0; bus_valid = 1; bus_addr = cfg_addr; bus_data = cfg_data;
        step("R9 disabled", "R9 disabled");
        cfg_en = 1;
        // R1: missing strobe
        bus_valid = 0;
        step("R1 no valid", "R1 no valid");
        bus_valid = 1;
        step("R1 hit", "R1 hit");
        step("R1 back-to-back", "R1 back-to-back");

        // R2: flip every single address bit
        for (int b = 0; b < AW; b++) begin
            bus_addr = cfg_addr ^ (23'(1) << b);
            step("R2 addr bit", "R2 addr bit");
        end
        bus_addr = cfg_addr;

        // R3: direction sweep
        for (int k = 0; k < 8; k++) begin
            {cfg_rwe, cfg_rd, bus_rd} = 3'(k);
            step("R3 direction", "R3 direction");
        end
        cfg_rwe = 0;

        // R4/R5/R6/R7/R8: exhaustive sweep over data, mask and mode bits
        for (int d = 0; d < 16; d++)
            for (int m = 0; m < 16; m++)
                for (int k = 0; k < 32; k++) begin
                    bus_data = 4'(d); cfg_mask = 4'(m);
                    {cfg_invert, cfg_tag, cfg_size_en, bus_word, cfg_size_word} = 5'(k);
                    step("R4/R5/R6/R8 data variant", "R6/R7/R8 size variant");
                end

        // R5: all bits masked, inequality never passes on the data variant
        cfg_tag = 0; cfg_invert = 1; cfg_mask = 4'h0; bus_data = 4'h5;
        step("R5 all masked", "R8 size variant");
        // R9: disable again after a hit
        cfg_invert = 0; cfg_en = 1; cfg_size_en = 0;
        step("R4 all masked eq", "R1 hit");
        cfg_en = 0;
        step("R9 disabled", "R9 disabled");
        done = 1;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
        end
    end

    initial begin
        wait (done || $time > 100000);
        #1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule